// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level tree of translation tables in memory. The upper ten address bits select a word in the root table. That word either points at a second-level table or says that no such table exists. The middle ten bits then select a word in that second-level table, which gives the physical frame. The twelve low bits are the byte offset inside a 4 KB page and pass through unchanged.

A client presents a request while the walker is idle. The walker then issues its reads one level at a time on a simple request/ready memory port. It ends each walk with either a one-cycle completion pulse that carries the physical address, or a one-cycle fault pulse that carries the level at which a missing table or page was found. The root table address comes from a root register supplied on an input, and it is sampled when a request is accepted. Every table word is 32 bits wide. Bits 31:12 hold a page-aligned physical base, or the frame number. Bit 0 is the present flag.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: A request is taken only when `busy` is low. A `req_valid` pulse while busy causes no extra walk and does not change the result or the reads of the walk in progress.
- R3: The first read of a walk goes to address `root_base + va[31:22]*4`, using the root base sampled at acceptance.
- R4: When the root word has bit 0 set, the second read goes to address `{root_word[31:12], 12'h000} + va[21:12]*4`.
- R5: When both words have bit 0 set, `done` pulses with `pa_out = {leaf_word[31:12], va[11:0]}` and `fault_level` = 0.
- R6: When the root word has bit 0 clear, `fault` pulses with `fault_level` = 1 after exactly one memory read, and no second read is issued.
- R7: When the leaf word has bit 0 clear, `fault` pulses with `fault_level` = 2 after exactly two memory reads.
- R8: `busy` rises in the cycle after acceptance. It stays high through the cycle in which `done` or `fault` is high, and it is low in the cycle after that.
- R9: Once `mem_req` is raised, it stays high with a stable `mem_addr` until a cycle in which `mem_ready` is high.
- R10: `done` and `fault` are never high together, and each is high for one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical address of the root table |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: translation complete |
| fault | output | 1 | One-cycle pulse: missing entry found |
| fault_level | output | 2 | 1 = root word absent, 2 = leaf word absent, 0 = none |
| pa_out | output | 32 | Translated physical address, valid with `done` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the table word being read |
| mem_ready | input | 1 | Read completes this cycle; `mem_rdata` valid |
| mem_rdata | input | 32 | Table word returned by memory |

## Verification
The properties assume that memory raises `mem_ready` only while `mem_req` is high, and that each read completes in a single ready cycle with the data valid in that same cycle. The read counts behind the fault-level checks rely on this assumption. The bench's memory model follows the same rule. It waits a random latency of zero to three cycles after it sees a request, then holds ready high for exactly one cycle. It then restarts its latency count, because the walker keeps the request asserted into the second level. `req_valid` itself is unconstrained, and the bench pulses it both during walks and while the walker is idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TOP  = 2'd1,
        ST_LEAF = 2'd2,
        ST_RESP = 2'd3
    } walk_st_e;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_TOP  = 2'd1,
        LVL_LEAF = 2'd2
    } flt_lvl_e;

endpackage

// File: rtl/ptw_index_gen.sv
module ptw_index_gen #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int IDX_W     = 10,
    parameter int LEVELS    = 2,
    parameter int ENT_LOG2  = 2
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [PA_W-1:0] table_base,
    input  logic            leaf_sel,
    output logic [PA_W-1:0] entry_addr
);
    localparam int TOP_BIT = VA_W - 1;

    logic [IDX_W-1:0] idx [LEVELS];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign idx[l] = vaddr[TOP_BIT - l*IDX_W -: IDX_W];
    end

    logic [IDX_W-1:0] idx_sel;
    assign idx_sel = leaf_sel ? idx[LEVELS-1] : idx[0];

    assign entry_addr = table_base + (PA_W'(idx_sel) << ENT_LOG2);

endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk #(
    parameter int ENT_W       = 32,
    parameter int PA_W        = 32,
    parameter int OFF_W       = 12,
    parameter int PRESENT_BIT = 0
) (
    input  logic [ENT_W-1:0] entry,
    output logic             present,
    output logic [PA_W-1:0]  page_base
);
    assign present   = entry[PRESENT_BIT];
    assign page_base = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [PA_W-1:0] root_base,
    input  logic            mem_ready,
    input  logic            ent_present,
    input  logic [PA_W-1:0] ent_base,
    output logic [VA_W-1:0] walk_va,
    output logic [PA_W-1:0] walk_base,
    output logic            walk_leaf,
    output logic            mem_req,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic [1:0]      fault_level,
    output logic [PA_W-1:0] pa_out
);
    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] va;
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] pa;
        logic            done;
        logic            fault;
        flt_lvl_e        lvl;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_TOP;
                    r_d.va   = req_vaddr;
                    r_d.base = root_base;
                    r_d.lvl  = LVL_NONE;
                end
            end
            ST_TOP: begin
                if (mem_ready) begin
                    if (ent_present) begin
                        r_d.st   = ST_LEAF;
                        r_d.base = ent_base;
                    end else begin
                        r_d.st    = ST_RESP;
                        r_d.fault = 1'b1;
                        r_d.lvl   = LVL_TOP;
                    end
                end
            end
            ST_LEAF: begin
                if (mem_ready) begin
                    r_d.st = ST_RESP;
                    if (ent_present) begin
                        r_d.done = 1'b1;
                        r_d.pa   = {ent_base[PA_W-1:OFF_W], r_q.va[OFF_W-1:0]};
                    end else begin
                        r_d.fault = 1'b1;
                        r_d.lvl   = LVL_LEAF;
                    end
                end
            end
            ST_RESP: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, va: '0, base: '0, pa: '0,
                     done: 1'b0, fault: 1'b0, lvl: LVL_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign walk_va     = r_q.va;
    assign walk_base   = r_q.base;
    assign walk_leaf   = (r_q.st == ST_LEAF);
    assign mem_req     = (r_q.st == ST_TOP) || (r_q.st == ST_LEAF);
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign fault       = r_q.fault;
    assign fault_level = r_q.lvl;
    assign pa_out      = r_q.pa;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [PA_W-1:0] root_base,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic [1:0]      fault_level,
    output logic [PA_W-1:0] pa_out,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_ready,
    input  logic [31:0]     mem_rdata
);
    localparam int IDX_W    = (VA_W - OFF_W) / LEVELS;
    localparam int ENT_W    = 32;
    localparam int ENT_LOG2 = $clog2(ENT_W / 8);

    logic [VA_W-1:0] walk_va;
    logic [PA_W-1:0] walk_base;
    logic            walk_leaf;
    logic            ent_present;
    logic [PA_W-1:0] ent_base;

    ptw_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .root_base  (root_base),
        .mem_ready  (mem_ready),
        .ent_present(ent_present),
        .ent_base   (ent_base),
        .walk_va    (walk_va),
        .walk_base  (walk_base),
        .walk_leaf  (walk_leaf),
        .mem_req    (mem_req),
        .busy       (busy),
        .done       (done),
        .fault      (fault),
        .fault_level(fault_level),
        .pa_out     (pa_out)
    );

    ptw_index_gen #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W),
                    .LEVELS(LEVELS), .ENT_LOG2(ENT_LOG2)) u_idx (
        .vaddr     (walk_va),
        .table_base(walk_base),
        .leaf_sel  (walk_leaf),
        .entry_addr(mem_addr)
    );

    ptw_entry_chk #(.ENT_W(ENT_W), .PA_W(PA_W), .OFF_W(OFF_W),
                    .PRESENT_BIT(0)) u_ent (
        .entry    (mem_rdata),
        .present  (ent_present),
        .page_base(ent_base)
    );

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            done,
    input logic            fault,
    input logic [1:0]      fault_level,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_ready
);
    logic [1:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_cnt <= '0;
        else if (req_valid && !busy) rd_cnt <= '0;
        else if (mem_req && mem_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !busy && !mem_req);

    p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !mem_req);

    p_done_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fault_level == 2'd0 && rd_cnt == 2'd2);

    p_top_fault_one_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_level == 2'd1) |-> rd_cnt == 2'd1);

    p_leaf_fault_two_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_level == 2'd2) |-> rd_cnt == 2'd2);

    p_fault_has_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_level == 2'd1 || fault_level == 2'd2);

    p_busy_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_busy_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> busy);

    p_idle_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !busy);

    p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));

endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_level(fault_level),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = '0;
    logic        busy, done, fault, mem_req;
    logic [1:0]  fault_level;
    logic [31:0] pa_out, mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    int reads = 0;
    int lat = 0;
    logic [31:0] addr_log [4];
    logic [31:0] absent_a = 32'hFFFF_FFFF;
    logic [31:0] absent_b = 32'hFFFF_FFFF;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .root_base(root_base), .busy(busy), .done(done), .fault(fault),
        .fault_level(fault_level), .pa_out(pa_out), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] h;
        if (a == absent_a || a == absent_b) return 32'h0;
        h = (a ^ 32'h5BD1_E995) * 32'h9E37_79B1;
        h = h ^ (h >> 15);
        return {h[31:12], 11'h0, (h[9:7] != 3'd0)};
    endfunction

    // memory model: ready only while requested, one cycle, random latency
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            lat = int'($urandom % 4);
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_ready = 1'b1;
                mem_rdata = mem_word(mem_addr);
                if (reads < 4) addr_log[reads] = mem_addr;
                reads++;
            end else begin
                lat--;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] root, input bit inject);
        logic [31:0] a1, e1, a2, e2;
        int exp_reads, t;
        logic [1:0] exp_lvl;
        a1 = root + {20'h0, va[31:22], 2'b00};
        e1 = mem_word(a1);
        a2 = {e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        e2 = mem_word(a2);
        if (!e1[0]) begin exp_lvl = 2'd1; exp_reads = 1; end
        else if (!e2[0]) begin exp_lvl = 2'd2; exp_reads = 2; end
        else begin exp_lvl = 2'd0; exp_reads = 2; end

        @(negedge clk);
        reads = 0;
        req_valid = 1'b1; req_vaddr = va; root_base = root;
        @(negedge clk);
        req_valid = 1'b0;
        root_base = ~root;
        check(busy === 1'b1, "R8", "busy after accept", {31'h0, busy}, 32'h1);
        t = 0;
        while (!(done || fault) && t < 40) begin
            if (inject && t == 0) begin
                req_valid = 1'b1; req_vaddr = ~va;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        req_valid = 1'b0;
        check(t < 40, "R8", "walk finished", t, 40);
        check(addr_log[0] === a1, "R3", "first read address", addr_log[0], a1);
        if (exp_reads == 2)
            check(addr_log[1] === a2, "R4", "second read address", addr_log[1], a2);
        if (exp_lvl == 2'd0) begin
            check(done === 1'b1 && fault === 1'b0, "R5", "done pulse", {30'h0, done, fault}, 32'h2);
            check(pa_out === {e2[31:12], va[11:0]}, "R5", "physical address", pa_out, {e2[31:12], va[11:0]});
            check(fault_level === 2'd0, "R5", "level on success", {30'h0, fault_level}, 32'h0);
        end else begin
            check(fault === 1'b1 && done === 1'b0, exp_lvl == 2'd1 ? "R6" : "R7", "fault pulse",
                  {30'h0, done, fault}, 32'h1);
            check(fault_level === exp_lvl, exp_lvl == 2'd1 ? "R6" : "R7", "fault level",
                  {30'h0, fault_level}, {30'h0, exp_lvl});
        end
        check(reads == exp_reads, exp_lvl == 2'd1 ? "R6" : "R7", "read count", reads, exp_reads);
        check(busy === 1'b1, "R8", "busy in pulse cycle", {31'h0, busy}, 32'h1);
        @(negedge clk);
        check(busy === 1'b0, "R8", "idle after pulse", {31'h0, busy}, 32'h0);
        check(!done && !fault, "R10", "single pulse", {30'h0, done, fault}, 32'h0);
        if (inject) begin
            @(negedge clk);
            check(busy === 1'b0 && reads == exp_reads, "R2", "ignored request while busy",
                  reads, exp_reads);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] va, root, e1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !done && !fault && !mem_req, "R1", "outputs in reset",
              {28'h0, busy, done, fault, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fault && !mem_req, "R1", "outputs after reset",
              {28'h0, busy, done, fault, mem_req}, 32'h0);

        // R6: directed absent root word, highest top index
        va = 32'hFFC0_0ABC; root = 32'h0010_0000;
        absent_a = root + {20'h0, va[31:22], 2'b00};
        walk(va, root, 1'b0);
        // R7: directed absent leaf word, index zero
        absent_a = 32'hFFFF_FFFF;
        va = 32'h0000_0FFF; root = 32'h0020_0000;
        e1 = mem_word(root);
        if (!e1[0]) begin root = 32'h0020_1000; e1 = mem_word(root); end
        absent_b = {e1[31:12], 12'h0};
        walk(va, root, 1'b0);
        absent_b = 32'hFFFF_FFFF;
        // R2: request pulsed while busy is ignored
        walk(32'h1234_5678, 32'h0030_0000, 1'b1);
        walk(32'h0040_1001, 32'h0031_0000, 1'b1);

        for (int i = 0; i < 400; i++) begin
            va = $urandom;
            root = {$urandom, 12'h0} >> 12 << 12;
            walk(va, root, (i % 7) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule